// File: doc/BRIEF.md
# Board Interrupt Level Encoder

This block collects thirteen level-sensitive interrupt requests from the peripherals on a board. It turns them into one 4-bit urgency code for the CPU. Each request line has a fixed priority level and a fixed bit in a 16-bit pending vector, and the two are unrelated. The pending vector is ANDed with a software mask. Of the requests that survive the mask, the one with the smallest level number wins. The block registers that level XOR 15, so the code is 0 when nothing is requesting and 15 for the most urgent source.

Software reaches the block through a 16-bit register window of 64 bytes on a plain synchronous bus. There is no back-pressure: every access takes one cycle, a write commits at the clock edge that samples it, and read data is driven combinationally in the same cycle. The window contains four registers:
- the interrupt mask
- a general output latch that drives pins
- a power-off control that emits a one-cycle shutdown pulse
- a constant version code

The request inputs are expected to be synchronous to the block clock.

Top module: `irq_level_encoder`

## Requirements
- R1: Request line `irq_req[i]` has priority level i. Its pending bit is, by level 0..12: 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15, and pending bits 1, 2 and 3 are never used. A pending bit follows its input with no latching: when one enabled line rises, the code becomes its level XOR 15 at the next clock edge, and it returns to 0 at the edge after the line drops.
- R2: When several requests are both pending and enabled, `irq_level` takes the value (smallest such level) XOR 15 at the clock edge that samples the inputs.
- R3: When no request is both pending and enabled, `irq_level` is 0 after the next edge.
- R4: Offset 0x00 holds the 16-bit mask and reads back the stored value. A write changes the mask at the sampling edge, and `irq_level` reflects the new mask from the edge that follows.
- R5: Offset 0x36 holds a 16-bit output latch. It drives `out_port` from the edge after the write and reads back the stored value.
- R6: Offset 0x30 reads as 0. A write to it with data bit 0 set raises `shutdown_pulse` for the one cycle after the write edge. A write with bit 0 clear, or any access elsewhere, leaves it low.
- R7: Offset 0x32 reads 0x0010, and writes to it change nothing.
- R8: Any other offset, odd offsets included, reads 0, and writes to it change neither the mask nor the output latch. `bus_rdata` is 0 in any cycle without a read.
- R9: Asynchronous active-low reset clears the mask, the output latch, `shutdown_pulse` and `irq_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 13 | Level request lines, index = priority level |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset inside the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle |
| out_port | output | 16 | Output latch contents |
| shutdown_pulse | output | 1 | One-cycle power-off request |
| irq_level | output | 4 | Registered urgency code, 0 = idle |

## Verification
The hardest case to bring about is a tie-break between enabled lines whose pending bits lie in a different order from their levels, with a mask that changes while the lines are still asserted. The mask's extra edge of latency then shows up alone. The stimulus first walks each line on its own under a full mask. It then raises every line at once and drops them from the most urgent downward. After that come several hundred cycles in which new request patterns arrive every cycle and mask writes are interleaved. The behavioural model is compared on each cycle throughout.

// File: rtl/irqenc_pkg.sv
package irqenc_pkg;
  localparam int unsigned OFS_MASK = 'h00;
  localparam int unsigned OFS_PWR  = 'h30;
  localparam int unsigned OFS_VER  = 'h32;
  localparam int unsigned OFS_PORT = 'h36;

  // pending-vector bit owned by the request line of a given priority level
  function automatic int unsigned lvl_to_bit(int unsigned lvl);
    case (lvl)
      0:  return 11;
      1:  return 9;
      2:  return 8;
      3:  return 12;
      4:  return 10;
      5:  return 6;
      6:  return 5;
      7:  return 4;
      8:  return 7;
      9:  return 14;
      10: return 13;
      11: return 0;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/irqenc_prio.sv
module irqenc_prio
  import irqenc_pkg::*;
#(
  parameter int N_SRC  = 13,
  parameter int DATA_W = 16,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  req,
  input  logic [DATA_W-1:0] mask,
  output logic [LVL_W-1:0]  level
);
  localparam logic [LVL_W-1:0] IDLE = {LVL_W{1'b1}};

  logic [DATA_W-1:0] pending;
  logic [N_SRC-1:0]  elig;
  logic [LVL_W-1:0]  win;

  always_comb begin
    pending = '0;
    for (int i = 0; i < N_SRC; i++) pending[lvl_to_bit(i)] = req[i];
  end

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_elig
      localparam int unsigned B = lvl_to_bit(g);
      assign elig[g] = pending[B] & mask[B];
    end
  endgenerate

  always_comb begin
    win = IDLE;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (elig[i]) win = LVL_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else        level <= win ^ IDLE;
  end

  assert_top_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    elig[0] |=> level == IDLE);
  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req) |=> level == '0);
endmodule

// File: rtl/irqenc_regs.sv
module irqenc_regs
  import irqenc_pkg::*;
#(
  parameter int              DATA_W  = 16,
  parameter int              ADDR_W  = 6,
  parameter logic [DATA_W-1:0] VERSION = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] port_q,
  output logic              shut_q
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(OFS_PWR);
  localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(OFS_VER);
  localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(OFS_PORT);

  logic wr, rd;
  assign wr = en & we;
  assign rd = en & ~we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      port_q <= '0;
      shut_q <= 1'b0;
    end else begin
      if (wr && addr == A_MASK) mask_q <= wdata;
      if (wr && addr == A_PORT) port_q <= wdata;
      shut_q <= wr && addr == A_PWR && wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        A_MASK:  rdata = mask_q;
        A_PORT:  rdata = port_q;
        A_VER:   rdata = VERSION;
        default: rdata = '0;
      endcase
    end
  end

  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == A_MASK) |=> $stable(mask_q));
  assert_port_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == A_PORT) |=> $stable(port_q));
  assert_pulse_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_PWR && wdata[0]) |=> shut_q);
  assert_pulse_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == A_PWR) |=> !shut_q);
  assert_ver_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_VER) |-> rdata == VERSION);
endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder #(
  parameter int                N_SRC   = 13,
  parameter int                DATA_W  = 16,
  parameter int                ADDR_W  = 6,
  parameter logic [DATA_W-1:0] VERSION = 16'h0010,
  localparam int               LVL_W   = $clog2(N_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] out_port,
  output logic              shutdown_pulse,
  output logic [LVL_W-1:0]  irq_level
);
  logic [DATA_W-1:0] mask;

  irqenc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .en(bus_en), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .mask_q(mask), .port_q(out_port),
    .shut_q(shutdown_pulse)
  );

  irqenc_prio #(.N_SRC(N_SRC), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .mask(mask), .level(irq_level)
  );

  assert_reset_clear_R9: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq_level == '0 && out_port == '0 && !shutdown_pulse));
endmodule

// File: tb/irq_level_encoder_tb.sv
module irq_level_encoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] irq_req = '0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata, out_port;
  logic        shutdown_pulse;
  logic [3:0]  irq_level;

  always #2 clk = ~clk;

  irq_level_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .out_port(out_port), .shutdown_pulse(shutdown_pulse), .irq_level(irq_level)
  );

  // R1 table: pending bit per level
  int bit_of[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  int m_mask = 0, m_port = 0, m_lvl = 0, m_shut = 0;

  // behavioural reference, advanced on every edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_port = 0; m_lvl = 0; m_shut = 0;
    end else begin
      int best;
      best = 15;
      for (int i = 12; i >= 0; i--)
        if (irq_req[i] && ((m_mask >> bit_of[i]) & 1) == 1) best = i;
      m_lvl = best ^ 15;
      m_shut = (bus_en && bus_we && bus_addr == 6'h30 && bus_wdata[0]) ? 1 : 0;
      if (bus_en && bus_we && bus_addr == 6'h00) m_mask = bus_wdata;
      if (bus_en && bus_we && bus_addr == 6'h36) m_port = bus_wdata;
    end
  end

  function automatic int exp_rdata();
    if (!bus_en || bus_we) return 0;
    case (bus_addr)
      6'h00: return m_mask;
      6'h36: return m_port;
      6'h32: return 'h0010;
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag();
    if (!bus_en || bus_we) return "R8";
    case (bus_addr)
      6'h00: return "R4";
      6'h36: return "R5";
      6'h30: return "R6";
      6'h32: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      string lt;
      if (!rst_n) lt = "R9";
      else if (m_lvl == 0) lt = "R3";
      else if ($countones(irq_req) == 1) lt = "R1";
      else lt = "R2";
      chk(lt, int'(irq_level), m_lvl, "irq_level");
      chk(rst_n ? "R6" : "R9", int'(shutdown_pulse), m_shut, "shutdown_pulse");
      chk(rst_n ? "R5" : "R9", int'(out_port), m_port, "out_port");
      chk(rd_tag(), int'(bus_rdata), exp_rdata(), "bus_rdata");
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic bus_wr(logic [5:0] a, logic [15:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(logic [5:0] a);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    step();
    bus_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung run, expected completion");
    finish_run();
  end

  initial begin
    // R9: reset state observed at negedges while held
    repeat (3) step();
    rst_n = 1'b1;
    step();
    bus_rd(6'h00);
    // R1: every line alone under a full mask, and its release
    bus_wr(6'h00, 16'hFFFF);
    for (int i = 0; i < 13; i++) begin
      irq_req = 13'(1 << i); step(); step();
      irq_req = '0; step();
    end
    // R2: all lines together, dropping the most urgent each step
    irq_req = '1; step();
    for (int i = 0; i < 13; i++) begin
      irq_req[i] = 1'b0; step();
    end
    // R4: mask change while lines are held
    irq_req = 13'h1FFF;
    bus_wr(6'h00, 16'h8001); step();
    bus_wr(6'h00, 16'h0000); step();
    bus_wr(6'h00, 16'h0E00); bus_rd(6'h00); step();
    // R5, R6, R7, R8
    bus_wr(6'h36, 16'hA5C3); bus_rd(6'h36);
    bus_wr(6'h30, 16'h0001); step();
    bus_wr(6'h30, 16'hFFFE); bus_rd(6'h30);
    bus_wr(6'h30, 16'h0001); bus_wr(6'h30, 16'h0003);
    bus_wr(6'h32, 16'h1234); bus_rd(6'h32);
    bus_wr(6'h02, 16'h0000); bus_wr(6'h3E, 16'hFFFF); bus_wr(6'h01, 16'h1111);
    bus_wr(6'h37, 16'h0);
    bus_rd(6'h00); bus_rd(6'h36); bus_rd(6'h3E); bus_rd(6'h35);
    // mixed traffic: R2 ties with a moving mask
    for (int n = 0; n < 800; n++) begin
      int op;
      logic [5:0] a;
      irq_req = 13'($urandom);
      op = $urandom_range(0, 5);
      case ($urandom_range(0, 5))
        0: a = 6'h00;
        1: a = 6'h30;
        2: a = 6'h32;
        3: a = 6'h36;
        default: a = 6'($urandom_range(0, 63));
      endcase
      if (op == 0) bus_wr(a, 16'($urandom));
      else if (op == 1) bus_rd(a);
      else step();
    end
    // R9: reset in the middle of activity
    irq_req = '1; bus_wr(6'h00, 16'hFFFF); bus_wr(6'h36, 16'h00FF);
    rst_n = 1'b0; step(); step();
    rst_n = 1'b1; irq_req = '0; step(); step();
    finish_run();
  end
endmodule